// File: doc/BRIEF.md
# Key-Gated Power Control Register

A single 16-bit power-control register on a simple write/read port with no address and two byte lanes. The upper byte serves as an unlock key. It never stores what is written and always reads back a fixed identifier. The lower byte holds the control bits. These bits change only through an accepted write. A write is accepted when it carries the correct key in the same cycle, or when it follows an earlier unlocking write.

The stored bits drive three things:
- A supervisor-enable output. It is forced on in shallow power modes and follows its control bit in deep modes.
- A regulator-off request. It turns the two deepest sleep modes into their shutdown variants on an effective-mode output.
- Two self-clearing trigger bits. Each one emits a one-cycle reset pulse.

Top module: `pwr_ctrl_reg`

## Requirements
- R1: After a synchronous reset, the read value is 0x9640, `sup_en` is 1, `eff_mode` is 0, and `reg_off` and both pulse outputs are 0. The key state is locked.
- R2: Read bits 15..8 always return 0x96, whatever was written. Bits 5, 1 and 0 always read 0. Read bit 7 is the spare bit, bit 6 the supervisor bit, bit 4 the regulator-off bit, bit 3 the power-on-reset trigger and bit 2 the brownout trigger.
- R3: While the key state is locked, a write that enables only the lower byte lane changes no read bit and produces no pulse.
- R4: A write with the upper lane enabled and data 0xA5 there unlocks the key state and applies its lower-byte data in the same cycle. A write with the upper lane enabled and any other upper value relocks and discards its lower-byte data. Once unlocked, writes to the lower lane alone are applied.
- R5: Bit 7 is stored and read back as written by an accepted write.
- R6: `sup_en` is 1 whenever the supervisor bit is 1. When that bit is 0, `sup_en` is 1 for mode codes 0, 1 and 2 (active, LPM0, LPM1) and 0 for codes 3 to 7.
- R7: With the regulator-off bit set, mode 4 (LPM3) gives `eff_mode` 6 and mode 5 (LPM4) gives `eff_mode` 7, each with `reg_off` 1. In every other case, `eff_mode` equals the input mode and `reg_off` is 0.
- R8: An accepted write with bit 3 at 1 makes read bit 3 and `por_pulse` 1 for exactly the next cycle. Both return to 0 after that unless the write is repeated.
- R9: An accepted write with bit 2 at 1 makes read bit 2 and `bor_pulse` 1 for exactly the next cycle, in the same way.
- R10: `sup_en`, `eff_mode` and `reg_off` are registered. Each reflects the mode input and control bits as they stood one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte-lane enables: bit 1 upper, bit 0 lower |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read value |
| lpm_in | input | 3 | Current low-power mode code |
| sup_en | output | 1 | High-side supervisor enable |
| eff_mode | output | 3 | Effective mode, 6 and 7 for shutdown variants |
| reg_off | output | 1 | Regulator-off request |
| por_pulse | output | 1 | Software power-on-reset pulse |
| bor_pulse | output | 1 | Software brownout-reset pulse |

## Verification
The key check and the lower-byte update can fall in the same cycle when one write carries both lanes. The bench provokes this with correct and wrong keys, combined with lower data that sets the triggers and the mode bits. It judges the result by the read value and the pulses on the following cycle. A control-bit update can also coincide with a change on the mode input. Random traffic produces this overlap, and the reference model decides whether the old or the new bit governs each output at every clock.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  localparam int DATA_W   = 16;
  localparam int BYTE_W   = DATA_W / 2;
  localparam int MODE_W   = 3;
  localparam logic [BYTE_W-1:0] UNLOCK_KEY = 8'hA5;
  localparam logic [BYTE_W-1:0] READ_ID    = 8'h96;
  // bit positions inside the lower byte
  localparam int B_SPARE = 7;
  localparam int B_SUP   = 6;
  localparam int B_ROFF  = 4;
  localparam int B_POR   = 3;
  localparam int B_BOR   = 2;
  // mode codes
  localparam logic [MODE_W-1:0] M_LPM1   = 3'd2;
  localparam logic [MODE_W-1:0] M_LPM3   = 3'd4;
  localparam logic [MODE_W-1:0] M_LPM4   = 3'd5;
  localparam logic [MODE_W-1:0] M_LPM3_5 = 3'd6;
  localparam logic [MODE_W-1:0] M_LPM4_5 = 3'd7;

  typedef struct packed {
    logic spare;
    logic sup;
    logic roff;
    logic por;
    logic bor;
  } ctrl_bits_t;
endpackage

// File: rtl/pwr_key_gate.sv
module pwr_key_gate
  import pwr_ctrl_pkg::*;
#(
  parameter int KW = BYTE_W,
  parameter logic [KW-1:0] KEY = UNLOCK_KEY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_be,
  input  logic [KW-1:0] wr_key,
  output logic          apply_lo,
  output logic          unlocked
);
  logic key_ok;
  logic upper_wr;

  assign upper_wr = wr_en && wr_be[1];
  assign key_ok   = (wr_key == KEY);
  assign apply_lo = wr_en && wr_be[0] && (wr_be[1] ? key_ok : unlocked);

  always_ff @(posedge clk) begin
    if (rst)           unlocked <= 1'b0;
    else if (upper_wr) unlocked <= key_ok;
  end

  AST_WRONG_KEY_RELOCK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[1] && wr_key != KEY) |=> !unlocked); // R4
  AST_LOCKED_LOWER_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_be[1] && !unlocked) |-> !apply_lo); // R3
endmodule

// File: rtl/pwr_ctrl_bits.sv
module pwr_ctrl_bits
  import pwr_ctrl_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          apply_lo,
  input  logic [BW-1:0] lo_data,
  output ctrl_bits_t    bits
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bits.spare <= 1'b0;
      bits.sup   <= 1'b1;
      bits.roff  <= 1'b0;
      bits.por   <= 1'b0;
      bits.bor   <= 1'b0;
    end else begin
      if (apply_lo) begin
        bits.spare <= lo_data[B_SPARE];
        bits.sup   <= lo_data[B_SUP];
        bits.roff  <= lo_data[B_ROFF];
      end
      bits.por <= apply_lo && lo_data[B_POR];
      bits.bor <= apply_lo && lo_data[B_BOR];
    end
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !apply_lo) |=> $stable({bits.spare, bits.sup, bits.roff})); // R3
  AST_POR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bits.por |-> $past(apply_lo && lo_data[B_POR])); // R8
  AST_BOR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bits.bor |-> $past(apply_lo && lo_data[B_BOR])); // R9
  AST_POR_SELFCLR: assert property (@(posedge clk) disable iff (rst)
    (!rst && !apply_lo) |=> !bits.por); // R8
endmodule

// File: rtl/pwr_mode_qual.sv
module pwr_mode_qual
  import pwr_ctrl_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] lpm_in,
  input  logic          sup_bit,
  input  logic          roff_bit,
  output logic          sup_en,
  output logic [MW-1:0] eff_mode,
  output logic          reg_off
);
  logic          shallow;
  logic          deep3;
  logic          deep4;
  logic [MW-1:0] eff_nxt;

  assign shallow = (lpm_in <= M_LPM1);
  assign deep3   = (lpm_in == M_LPM3);
  assign deep4   = (lpm_in == M_LPM4);

  always_comb begin
    eff_nxt = lpm_in;
    if (roff_bit && deep3) eff_nxt = M_LPM3_5;
    else if (roff_bit && deep4) eff_nxt = M_LPM4_5;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_en   <= 1'b1;
      eff_mode <= '0;
      reg_off  <= 1'b0;
    end else begin
      sup_en   <= sup_bit || shallow;
      eff_mode <= eff_nxt;
      reg_off  <= roff_bit && (deep3 || deep4);
    end
  end

  AST_SUP_SHALLOW: assert property (@(posedge clk) disable iff (rst)
    (!rst && lpm_in <= M_LPM1) |=> sup_en); // R6
  AST_SUP_BIT_ON: assert property (@(posedge clk) disable iff (rst)
    (!rst && sup_bit) |=> sup_en); // R6
  AST_LPM35_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!rst && roff_bit && lpm_in == M_LPM3) |=> (eff_mode == M_LPM3_5 && reg_off)); // R7
  AST_NO_ROFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (!rst && !roff_bit) |=> (eff_mode == $past(lpm_in) && !reg_off)); // R10
endmodule

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [MODE_W-1:0] lpm_in,
  output logic              sup_en,
  output logic [MODE_W-1:0] eff_mode,
  output logic              reg_off,
  output logic              por_pulse,
  output logic              bor_pulse
);
  logic       apply_lo;
  logic       unlocked;
  ctrl_bits_t bits;

  pwr_key_gate #(.KW(BYTE_W), .KEY(UNLOCK_KEY)) u_key (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be),
    .wr_key(wr_data[DATA_W-1:BYTE_W]), .apply_lo(apply_lo), .unlocked(unlocked)
  );

  pwr_ctrl_bits #(.BW(BYTE_W)) u_bits (
    .clk(clk), .rst(rst), .apply_lo(apply_lo),
    .lo_data(wr_data[BYTE_W-1:0]), .bits(bits)
  );

  pwr_mode_qual #(.MW(MODE_W)) u_mode (
    .clk(clk), .rst(rst), .lpm_in(lpm_in), .sup_bit(bits.sup),
    .roff_bit(bits.roff), .sup_en(sup_en), .eff_mode(eff_mode), .reg_off(reg_off)
  );

  always_comb begin
    rd_data                 = '0;
    rd_data[DATA_W-1:BYTE_W] = READ_ID;
    rd_data[B_SPARE]        = bits.spare;
    rd_data[B_SUP]          = bits.sup;
    rd_data[B_ROFF]         = bits.roff;
    rd_data[B_POR]          = bits.por;
    rd_data[B_BOR]          = bits.bor;
  end

  assign por_pulse = bits.por;
  assign bor_pulse = bits.bor;

  AST_PULSE_MATCHES_READ: assert property (@(posedge clk) disable iff (rst)
    (por_pulse == rd_data[B_POR]) && (bor_pulse == rd_data[B_BOR])); // R8
  AST_LOCK_BLOCKS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_en && !wr_be[1] && !unlocked) |=> (!por_pulse && !bor_pulse)); // R3
endmodule

// File: tb/test_pwr_ctrl_reg.sv
module test_pwr_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [2:0]  lpm_in = 3'd0;
  logic [15:0] rd_data;
  logic        sup_en, reg_off, por_pulse, bor_pulse;
  logic [2:0]  eff_mode;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit       m_unl;
  bit       m_spare, m_sup, m_roff, m_por, m_bor;
  bit       e_sup;
  bit       e_roff;
  int       e_eff;

  always #4 clk = ~clk;

  pwr_ctrl_reg i_pwr_ctrl_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .lpm_in(lpm_in), .sup_en(sup_en), .eff_mode(eff_mode),
    .reg_off(reg_off), .por_pulse(por_pulse), .bor_pulse(bor_pulse)
  );

  function automatic int exp_rd();
    return 'h9600 + (m_spare ? 'h80 : 0) + (m_sup ? 'h40 : 0) + (m_roff ? 'h10 : 0)
         + (m_por ? 'h08 : 0) + (m_bor ? 'h04 : 0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit key_ok, apply;
    int lp;
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (rst) begin
      m_unl = 0; m_spare = 0; m_sup = 1; m_roff = 0; m_por = 0; m_bor = 0;
      e_sup = 1; e_roff = 0; e_eff = 0;
    end else begin
      lp = int'(lpm_in);
      e_sup  = m_sup || lp <= 2;
      e_roff = m_roff && (lp == 4 || lp == 5);
      e_eff  = (m_roff && lp == 4) ? 6 : (m_roff && lp == 5) ? 7 : lp;
      key_ok = wr_data[15:8] == 8'hA5;
      apply  = wr_en && wr_be[0] && (wr_be[1] ? key_ok : m_unl);
      if (wr_en && wr_be[1]) m_unl = key_ok;
      m_por = apply && wr_data[3];
      m_bor = apply && wr_data[2];
      if (apply) begin
        m_spare = wr_data[7]; m_sup = wr_data[6]; m_roff = wr_data[4];
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk({cur_req, " rd_data"}, int'(rd_data), exp_rd());
      chk({cur_req, " sup_en R6"}, int'(sup_en), int'(e_sup));
      chk({cur_req, " eff_mode R7"}, int'(eff_mode), e_eff);
      chk({cur_req, " reg_off R7"}, int'(reg_off), int'(e_roff));
      chk({cur_req, " por_pulse R8"}, int'(por_pulse), int'(m_por));
      chk({cur_req, " bor_pulse R9"}, int'(bor_pulse), int'(m_bor));
    end
  end

  task automatic step(input bit w, input logic [1:0] be, input logic [15:0] d, input logic [2:0] lp);
    wr_en = w; wr_be = be; wr_data = d; lpm_in = lp;
    @(negedge clk);
  endtask

  task automatic idle(input logic [2:0] lp);
    step(1'b0, 2'b00, 16'h0, lp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1'b1;
    // R1 reset values
    chk("R1 reset read", int'(rd_data), 'h9640);
    chk("R1 reset sup_en", int'(sup_en), 1);
    chk("R1 reset eff_mode", int'(eff_mode), 0);
    chk("R1 reset pulses", int'({reg_off, por_pulse, bor_pulse}), 0);

    // R3 lower-only write while locked
    cur_req = "R3";
    step(1'b1, 2'b01, 16'h00DC, 3'd0);
    chk("R3 locked write ignored", int'(rd_data), 'h9640);
    chk("R3 no pulse when locked", int'({por_pulse, bor_pulse}), 0);

    // R4 wrong key with lower data discarded
    cur_req = "R4";
    step(1'b1, 2'b11, 16'h5ADC, 3'd0);
    chk("R4 wrong key discarded", int'(rd_data), 'h9640);

    // R4/R5/R8/R9 key plus data in one write, all lower bits
    step(1'b1, 2'b11, 16'hA5FF, 3'd0);
    chk("R4 same-cycle apply, R2 reserved zero", int'(rd_data), 'h96DC);
    chk("R8 por pulse", int'(por_pulse), 1);
    chk("R9 bor pulse", int'(bor_pulse), 1);
    idle(3'd0);
    chk("R8 R9 self clear", int'(rd_data), 'h96D0);
    chk("R8 pulse gone", int'({por_pulse, bor_pulse}), 0);

    // R4 unlocked: lower-only write applies; R5 spare bit
    cur_req = "R5";
    step(1'b1, 2'b01, 16'h1280, 3'd0);
    chk("R5 spare bit stored", int'(rd_data), 'h9680);
    // R2 upper byte never stored
    cur_req = "R2";
    step(1'b1, 2'b10, 16'hA500, 3'd0);
    chk("R2 upper reads id", int'(rd_data[15:8]), 'h96);

    // R8 single por only
    cur_req = "R8";
    step(1'b1, 2'b01, 16'h0008, 3'd0);
    chk("R8 por only", int'({por_pulse, bor_pulse}), 2);
    idle(3'd0);
    // R9 single bor only
    cur_req = "R9";
    step(1'b1, 2'b01, 16'h0004, 3'd0);
    chk("R9 bor only", int'({por_pulse, bor_pulse}), 1);
    idle(3'd0);

    // R6/R7/R10 mode sweeps for each bit combination
    for (int combo = 0; combo < 4; combo++) begin
      cur_req = (combo[0]) ? "R7" : "R6";
      step(1'b1, 2'b11, {8'hA5, 1'b0, combo[1], 1'b0, combo[0], 4'h0}, 3'd0);
      for (int lp = 0; lp < 8; lp++) begin
        idle(3'(lp));
        cur_req = "R10";
        idle(3'(lp));
        chk("R6 sup_en sweep", int'(sup_en), int'(combo[1] || lp <= 2));
        chk("R7 eff_mode sweep", int'(eff_mode),
            (combo[0] && lp == 4) ? 6 : (combo[0] && lp == 5) ? 7 : lp);
      end
    end

    // R4 relock then lower-only write ignored
    cur_req = "R4";
    step(1'b1, 2'b11, 16'h1100, 3'd0);
    step(1'b1, 2'b01, 16'h00C0, 3'd0);
    chk("R4 relocked write ignored", int'(rd_data[7:0]), 'h50);

    // random traffic, model compared every clock
    cur_req = "R10";
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if ($urandom_range(1, 0) == 1) d[15:8] = 8'hA5;
      step($urandom_range(3, 0) != 0, 2'($urandom), d, 3'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule